// File: doc/BRIEF.md
# Protection Fault Supervisor

This block collects every protection source of a power converter controller and runs the three-state core machine that decides whether the power stage may be driven. The three states are BLOCKED (control runs but gating is off), OPERATING (gating on) and FAULT (tripped, waiting to be cleared). The moment an enabled fault condition is visible, the PWM gate-enable drops in the same cycle, without waiting for the state register. Selected general-purpose outputs are also forced off, and the machine enters FAULT on the next edge.

Each source has a clear class, and the class decides how FAULT is left. Connector lines, dedicated fault inputs, the interlock, link errors and the user flag clear by themselves once no condition remains. The analog trip also needs an explicit acknowledge. A software fault holds FAULT until reset. Leaving FAULT always lands in BLOCKED, and a separate enable request is needed to reach OPERATING. A latched cause vector records every source class that tripped and empties when FAULT is left.

Top module: `prot_fault_hub`

## Requirements
- R1: After reset the state is BLOCKED (state code 0), the cause vector is 0, the colour is orange and the PWM gate-enable is 0. The PWM gate-enable is 1 only in OPERATING (state code 1).
- R2: In the cycle an enabled fault condition is visible after synchronization, the PWM gate-enable is 0. On the next rising edge the state becomes FAULT (state code 2).
- R3: Bit i of the GPO gate mask is 0 only when bit i of the GPO trip configuration is set and the block is in FAULT or a fault condition is present. Every other bit is 1.
- R4: The four connector fault lines are active-low and pass through a two-flop synchronizer. A low line trips with cause bit 0.
- R5: The 24 dedicated fault lines are active-high and synchronized. Each is ignored while its enable bit is 0, and trips with cause bit 1 when enabled.
- R6: The interlock input is active-low and synchronized. It is ignored while the interlock enable is 0, and otherwise trips with cause bit 2.
- R7: A CRC error, a code or disparity error, or a link loss each trip with cause bit 3.
- R8: If only automatic-class causes are latched (bits 0 to 4, with the user fault as bit 4), FAULT goes to BLOCKED on the first edge at which no condition is present.
- R9: An analog trip or condition-present signal trips with cause bit 5. Once bit 5 is latched, FAULT is left only by an acknowledge request while no condition is present.
- R10: A software fault trips with cause bit 6. FAULT then stays until reset, whatever the acknowledge and enable requests do.
- R11: No acknowledge takes effect while any condition is present. Enable requests have no effect in FAULT.
- R12: An enable request moves BLOCKED to OPERATING when no condition is present. A disable request moves OPERATING to BLOCKED. FAULT never goes straight to OPERATING.
- R13: The colour code is 1 (green) in OPERATING, 2 (orange) in BLOCKED and 3 (red) in FAULT.
- R14: The cause vector accumulates the bits of all sources that tripped while in FAULT, and reads 0 once FAULT is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conn_flt_n | input | N_CONN | Active-low connector fault lines |
| ded_flt | input | N_DED | Active-high dedicated fault lines |
| ded_en | input | N_DED | Per-line enable for dedicated lines |
| ilk_n | input | 1 | Active-low interlock input |
| ilk_en | input | 1 | Interlock enable |
| link_crc_err | input | 1 | Link CRC error |
| link_code_err | input | 1 | Link invalid code or disparity error |
| link_lost | input | 1 | Link loss |
| usr_flt | input | 1 | User fault flag |
| ana_trip | input | 1 | Analog over-value trip |
| ana_present | input | 1 | Analog over-value condition still present |
| sw_flt | input | 1 | Software fault (crash or overrun) |
| en_req | input | 1 | Enable request |
| dis_req | input | 1 | Disable request |
| ack_req | input | 1 | Acknowledge request |
| gpo_trip_mask | input | N_GPO | GPO bits to force off on a trip |
| pwm_en | output | 1 | Global PWM gate-enable |
| gpo_gate | output | N_GPO | GPO gate mask, 1 = output allowed |
| state_o | output | 2 | Core state code |
| colour_o | output | 2 | Status colour code |
| cause_o | output | 7 | Latched cause vector |

## Verification
The bench sweeps every connector line and every dedicated line. Each dedicated line is tried both masked and unmasked, so a swapped or stuck enable bit would show as a missed trip or a spurious trip. Each trip is checked at the exact edge the synchronizer delay predicts: a design that waits for the state register before gating would leave PWM on for one cycle, and an extra or missing synchronizer stage would shift both the trip and the clear by a cycle. The analog and software classes are driven with acknowledge and enable requests while conditions persist and after they vanish. A design that cleared them automatically, took an acknowledge too early, or let enable leave FAULT would end in the wrong state. A mixed user and analog trip checks that the strictest latched class governs the clear.

// File: rtl/prot_pkg.sv
package prot_pkg;
   typedef enum logic [1:0] {
      ST_BLOCKED = 2'd0,
      ST_RUN     = 2'd1,
      ST_FAULT   = 2'd2
   } core_state_e;

   typedef enum logic [1:0] {
      COL_OFF    = 2'd0,
      COL_GREEN  = 2'd1,
      COL_ORANGE = 2'd2,
      COL_RED    = 2'd3
   } colour_e;

   localparam int N_CAUSE   = 7;
   localparam int C_CONN    = 0;
   localparam int C_DED     = 1;
   localparam int C_ILK     = 2;
   localparam int C_LINK    = 3;
   localparam int C_USER    = 4;
   localparam int C_ANALOG  = 5;
   localparam int C_SW      = 6;
endpackage

// File: rtl/prot_sync.sv
module prot_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= {W{RST_VAL}};
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= {W{RST_VAL}};
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/prot_src_merge.sv
module prot_src_merge
   import prot_pkg::*;
#(
   parameter int N_CONN = 4,
   parameter int N_DED  = 24
) (
   input  logic [N_CONN-1:0] conn_s_n,
   input  logic [N_DED-1:0]  ded_s,
   input  logic [N_DED-1:0]  ded_en,
   input  logic              ilk_s_n,
   input  logic              ilk_en,
   input  logic              link_crc_err,
   input  logic              link_code_err,
   input  logic              link_lost,
   input  logic              usr_flt,
   input  logic              ana_trip,
   input  logic              ana_present,
   input  logic              sw_flt,
   output logic [N_CAUSE-1:0] cond
);
   always_comb begin
      cond           = '0;
      cond[C_CONN]   = |(~conn_s_n);
      cond[C_DED]    = |(ded_s & ded_en);
      cond[C_ILK]    = ilk_en & ~ilk_s_n;
      cond[C_LINK]   = link_crc_err | link_code_err | link_lost;
      cond[C_USER]   = usr_flt;
      cond[C_ANALOG] = ana_trip | ana_present;
      cond[C_SW]     = sw_flt;
   end
endmodule

// File: rtl/prot_core_fsm.sv
module prot_core_fsm
   import prot_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CAUSE-1:0] cond,
   input  logic               en_req,
   input  logic               dis_req,
   input  logic               ack_req,
   output core_state_e        st,
   output logic [N_CAUSE-1:0] cause,
   output colour_e            colour
);
   core_state_e        st_nxt;
   logic [N_CAUSE-1:0] cause_nxt;
   logic               any_cond;
   logic               may_leave;

   assign any_cond  = |cond;
   assign may_leave = !cause[C_SW] && (!cause[C_ANALOG] || ack_req);

   always_comb begin
      st_nxt    = st;
      cause_nxt = cause;
      if (any_cond) begin
         st_nxt    = ST_FAULT;
         cause_nxt = cause | cond;
      end else begin
         case (st)
            ST_BLOCKED: if (en_req)  st_nxt = ST_RUN;
            ST_RUN:     if (dis_req) st_nxt = ST_BLOCKED;
            ST_FAULT: begin
               if (may_leave) begin
                  st_nxt    = ST_BLOCKED;
                  cause_nxt = '0;
               end
            end
            default:    st_nxt = ST_FAULT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_BLOCKED;
         cause <= '0;
      end else begin
         st    <= st_nxt;
         cause <= cause_nxt;
      end
   end

   always_comb begin
      case (st)
         ST_RUN:     colour = COL_GREEN;
         ST_BLOCKED: colour = COL_ORANGE;
         ST_FAULT:   colour = COL_RED;
         default:    colour = COL_OFF;
      endcase
   end
endmodule

// File: rtl/prot_fault_hub.sv
module prot_fault_hub
   import prot_pkg::*;
#(
   parameter int N_CONN      = 4,
   parameter int N_DED       = 24,
   parameter int N_GPO       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CONN-1:0]  conn_flt_n,
   input  logic [N_DED-1:0]   ded_flt,
   input  logic [N_DED-1:0]   ded_en,
   input  logic               ilk_n,
   input  logic               ilk_en,
   input  logic               link_crc_err,
   input  logic               link_code_err,
   input  logic               link_lost,
   input  logic               usr_flt,
   input  logic               ana_trip,
   input  logic               ana_present,
   input  logic               sw_flt,
   input  logic               en_req,
   input  logic               dis_req,
   input  logic               ack_req,
   input  logic [N_GPO-1:0]   gpo_trip_mask,
   output logic               pwm_en,
   output logic [N_GPO-1:0]   gpo_gate,
   output logic [1:0]         state_o,
   output logic [1:0]         colour_o,
   output logic [N_CAUSE-1:0] cause_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (N_CONN < 1 || N_DED < 1 || N_GPO < 1) begin : g_bad_width
      $error("source and output counts must be at least 1");
   end

   logic [N_CONN-1:0]  conn_s_n;
   logic [N_DED-1:0]   ded_s;
   logic               ilk_s_n;
   logic [N_CAUSE-1:0] cond_vec;
   logic               trip_now;
   core_state_e        st;
   colour_e            colour;
   logic [N_CAUSE-1:0] cause;

   prot_sync #(.W(N_CONN), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_conn (
      .clk(clk), .rst_n(rst_n), .d(conn_flt_n), .q(conn_s_n));
   prot_sync #(.W(N_DED), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ded (
      .clk(clk), .rst_n(rst_n), .d(ded_flt), .q(ded_s));
   prot_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ilk (
      .clk(clk), .rst_n(rst_n), .d(ilk_n), .q(ilk_s_n));

   prot_src_merge #(.N_CONN(N_CONN), .N_DED(N_DED)) u_merge (
      .conn_s_n(conn_s_n), .ded_s(ded_s), .ded_en(ded_en),
      .ilk_s_n(ilk_s_n), .ilk_en(ilk_en),
      .link_crc_err(link_crc_err), .link_code_err(link_code_err),
      .link_lost(link_lost), .usr_flt(usr_flt),
      .ana_trip(ana_trip), .ana_present(ana_present),
      .sw_flt(sw_flt), .cond(cond_vec));

   prot_core_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cond(cond_vec),
      .en_req(en_req), .dis_req(dis_req), .ack_req(ack_req),
      .st(st), .cause(cause), .colour(colour));

   assign trip_now = |cond_vec;
   assign pwm_en   = (st == ST_RUN) && !trip_now;

   for (genvar g = 0; g < N_GPO; g++) begin : g_gpo
      assign gpo_gate[g] = !(gpo_trip_mask[g] && (trip_now || st == ST_FAULT));
   end

   assign state_o  = st;
   assign colour_o = colour;
   assign cause_o  = cause;
endmodule

// File: rtl/prot_fault_hub_chk.sv
module prot_fault_hub_chk
   import prot_pkg::*;
#(
   parameter int N_GPO = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_CAUSE-1:0] cond,
   input logic               pwm_en,
   input logic [N_GPO-1:0]   gpo_gate,
   input logic [N_GPO-1:0]   gpo_trip_mask,
   input logic [1:0]         state_o,
   input logic [1:0]         colour_o,
   input logic [N_CAUSE-1:0] cause_o
);
   assert_pwm_only_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_en |-> state_o == 2'd1);
   assert_block_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|cond) |-> !pwm_en);
   assert_fault_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|cond) |=> state_o == 2'd2);
   assert_gpo_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd2 |-> (gpo_gate & gpo_trip_mask) == '0);
   assert_sw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2 && cause_o[C_SW]) |=> state_o == 2'd2);
   assert_no_ack_present_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2 && (|cond)) |=> state_o == 2'd2);
   assert_no_direct_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd2 |=> state_o != 2'd1);
   assert_red_fault_R13: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd2 |-> colour_o == 2'd3);
   assert_green_run_R13: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd1 |-> colour_o == 2'd1);
   assert_cause_clear_R14: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_o) == 2'd2 && state_o == 2'd0) |-> cause_o == '0);
endmodule

bind prot_fault_hub prot_fault_hub_chk #(.N_GPO(N_GPO)) u_chk (
   .clk(clk), .rst_n(rst_n), .cond(cond_vec), .pwm_en(pwm_en),
   .gpo_gate(gpo_gate), .gpo_trip_mask(gpo_trip_mask),
   .state_o(state_o), .colour_o(colour_o), .cause_o(cause_o));

// File: tb/tb_prot_fault_hub.sv
module tb_prot_fault_hub;
   localparam int NC = 4, ND = 24, NG = 8;
   localparam logic [1:0] S_BLK = 2'd0, S_RUN = 2'd1, S_FLT = 2'd2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NC-1:0] conn_flt_n = '1;
   logic [ND-1:0] ded_flt = '0, ded_en = '0;
   logic ilk_n = 1'b1, ilk_en = 1'b1;
   logic link_crc_err = 0, link_code_err = 0, link_lost = 0;
   logic usr_flt = 0, ana_trip = 0, ana_present = 0, sw_flt = 0;
   logic en_req = 0, dis_req = 0, ack_req = 0;
   logic [NG-1:0] gpo_trip_mask = 8'hA5;
   logic pwm_en;
   logic [NG-1:0] gpo_gate;
   logic [1:0] state_o, colour_o;
   logic [6:0] cause_o;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   prot_fault_hub #(.N_CONN(NC), .N_DED(ND), .N_GPO(NG), .SYNC_STAGES(2)) dut (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go_run();
      en_req = 1; tick(1); en_req = 0;
      chk("R12 enable to run", state_o, S_RUN);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      tick(2);
      chk("R1 reset state", state_o, S_BLK);
      chk("R1 reset pwm", pwm_en, 0);
      chk("R1 reset cause", cause_o, 0);
      chk("R13 reset colour orange", colour_o, 2);
      rst_n = 1; tick(1);
      chk("R3 gpo in blocked", gpo_gate, 8'hFF);
      go_run();
      chk("R1 pwm in run", pwm_en, 1);
      chk("R13 green", colour_o, 1);
      chk("R3 gpo in run", gpo_gate, 8'hFF);

      // R4 connector lines, two-flop delay
      for (int i = 0; i < NC; i++) begin
         go_run();
         conn_flt_n[i] = 0; tick(2);
         chk("R2 pwm drops same cycle", pwm_en, 0);
         chk("R2 state not yet fault", state_o, S_RUN);
         tick(1);
         chk("R4 conn trip state", state_o, S_FLT);
         chk("R4 conn cause", cause_o, 7'h01);
         chk("R13 red", colour_o, 3);
         conn_flt_n[i] = 1; tick(2);
         chk("R8 still fault during sync", state_o, S_FLT);
         tick(1);
         chk("R8 conn auto clear", state_o, S_BLK);
         chk("R14 cause cleared", cause_o, 0);
      end

      // R5 dedicated lines, masked then enabled
      for (int j = 0; j < ND; j++) begin
         go_run();
         ded_flt[j] = 1; tick(3);
         chk("R5 masked line ignored", state_o, S_RUN);
         chk("R5 masked pwm", pwm_en, 1);
         ded_en[j] = 1; #1;
         chk("R2 pwm drops on enable", pwm_en, 0);
         tick(1);
         chk("R5 ded trip", state_o, S_FLT);
         chk("R5 ded cause", cause_o, 7'h02);
         ded_flt[j] = 0; ded_en[j] = 0; tick(1);
         chk("R8 ded auto clear", state_o, S_BLK);
      end

      // R6 interlock
      go_run();
      ilk_en = 0; ilk_n = 0; tick(3);
      chk("R6 disabled interlock ignored", state_o, S_RUN);
      ilk_en = 1; #1;
      chk("R2 interlock pwm", pwm_en, 0);
      tick(1);
      chk("R6 interlock cause", cause_o, 7'h04);
      ilk_n = 1; tick(3);
      chk("R8 interlock clear", state_o, S_BLK);

      // R7 link errors
      for (int k = 0; k < 3; k++) begin
         go_run();
         {link_lost, link_code_err, link_crc_err} = 3'(1 << k); #1;
         chk("R2 link pwm", pwm_en, 0);
         tick(1);
         chk("R7 link cause", cause_o, 7'h08);
         {link_lost, link_code_err, link_crc_err} = 3'b0; tick(1);
         chk("R8 link clear", state_o, S_BLK);
      end

      // user fault with GPO mask
      go_run();
      usr_flt = 1; #1;
      chk("R3 gpo forced on trip", gpo_gate, 8'h5A);
      tick(1);
      chk("R8 user cause", cause_o, 7'h10);
      chk("R3 gpo in fault", gpo_gate, 8'h5A);
      usr_flt = 0; tick(1);
      chk("R8 user clear", state_o, S_BLK);
      chk("R3 gpo restored", gpo_gate, 8'hFF);

      // R9 / R11 analog
      go_run();
      ana_trip = 1; #1;
      chk("R2 analog pwm", pwm_en, 0);
      tick(1);
      chk("R9 analog cause", cause_o, 7'h20);
      ana_trip = 0; ana_present = 1; ack_req = 1; tick(2);
      chk("R11 ack ignored while present", state_o, S_FLT);
      ack_req = 0; en_req = 1; tick(1); en_req = 0;
      chk("R11 enable ignored in fault", state_o, S_FLT);
      ana_present = 0; tick(3);
      chk("R9 no auto clear", state_o, S_FLT);
      ack_req = 1; tick(1); ack_req = 0;
      chk("R9 ack clears to blocked", state_o, S_BLK);
      chk("R14 analog cause cleared", cause_o, 0);

      // R14 mixed classes
      go_run();
      usr_flt = 1; tick(1); ana_trip = 1; tick(1);
      chk("R14 cause accumulates", cause_o, 7'h30);
      usr_flt = 0; ana_trip = 0; tick(2);
      chk("R9 mixed needs ack", state_o, S_FLT);
      ack_req = 1; tick(1); ack_req = 0;
      chk("R9 mixed cleared", state_o, S_BLK);

      // R12 disable, ack in blocked
      go_run();
      dis_req = 1; tick(1); dis_req = 0;
      chk("R12 disable to blocked", state_o, S_BLK);
      ack_req = 1; tick(1); ack_req = 0;
      chk("R11 ack no effect in blocked", state_o, S_BLK);
      usr_flt = 1; en_req = 1; tick(1); en_req = 0;
      chk("R12 enable with fault goes fault", state_o, S_FLT);
      usr_flt = 0; tick(1);
      chk("R12 fault returns to blocked", state_o, S_BLK);

      // R10 software
      go_run();
      sw_flt = 1; tick(1); sw_flt = 0;
      chk("R10 sw cause", cause_o, 7'h40);
      tick(3);
      chk("R10 sw holds", state_o, S_FLT);
      ack_req = 1; tick(1); ack_req = 0;
      chk("R10 ack ignored", state_o, S_FLT);
      en_req = 1; tick(1); en_req = 0;
      chk("R10 enable ignored", state_o, S_FLT);
      rst_n = 0; tick(1);
      chk("R1 reset after sw", state_o, S_BLK);
      chk("R1 reset cause after sw", cause_o, 0);
      rst_n = 1; tick(1);
      chk("R1 pwm off after reset", pwm_en, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule